// File: doc/BRIEF.md
# Immediate-Offset Byte Load Unit

This unit takes an instruction stream one 16-bit halfword at a time, recognises three immediate-offset byte-load encodings (one short, two long), and carries each recognised load to completion. It reads the base register through a single read port, forms the effective address, issues one byte read on a valid/ready memory port, zero-extends the returned byte and writes it to the destination register. When the encoding asks for it, it also writes the updated address back to the base register in the same cycle. Encodings that belong to other instructions, or that are undefined or unpredictable, end with a one-cycle completion carrying a flag, and nothing is written or read from memory.

The controller has five states. ST_IDLE accepts a halfword. A leading half of a 32-bit instruction moves it to ST_HALF2. A recognised short load moves it to ST_ISSUE. Anything else moves it to ST_FLAG. ST_HALF2 accepts the second halfword and moves to ST_ISSUE for a recognised load, or to ST_FLAG otherwise. ST_ISSUE holds the memory request until it is accepted, then moves to ST_WAIT. ST_WAIT completes on the response strobe and returns to ST_IDLE. ST_FLAG pulses completion with one flag and returns to ST_IDLE.

Top module: `byteld_unit`

## Requirements
- R1: A single halfword with bits [15:11]=01111 is a short load. imm5 is taken from [10:6], the base from [5:3] and the destination from [2:0]. The read address is base+imm5. The destination receives the byte zero-extended to 32 bits, and the base is not written.
- R2: A halfword whose bits [15:11] are 11101, 11110 or 11111 is the first half of a 32-bit instruction. The unit keeps insn_ready high and issues no request and no completion until the second halfword arrives, however many idle cycles come between the two halves.
- R3: First half [15:4]=0xF89 is long form A. The base is in first-half [3:0], the destination in second-half [15:12] and imm12 in second-half [11:0]. The read address is base+imm12, and there is no base write.
- R4: First half [15:4]=0xF81 with second-half bit 11=1 is long form B. Bit 10 (pre) selects the address: base±imm8 when set, the plain base when clear. Bit 9 (add) selects + when set and − when clear. Bit 8 (wb) writes base±imm8 back to the base register. imm8 is in [7:0], and the arithmetic wraps modulo 2^32.
- R5: On either long form, a base field of 15 raises redir_literal.
- R6: Destination 15 raises redir_preload on form A, and on form B when pre=1, add=0, wb=0. This check has priority over every other flag.
- R7: Form B with pre=1, add=1, wb=0 raises redir_unpriv.
- R8: Form B with pre=0 and wb=0 raises undef_insn.
- R9: unpred_insn is raised for form A with destination 13. It is also raised for form B with destination 13 or 15, or with wb=1 and base equal to destination.
- R10: A flagged instruction gives a single-cycle done together with exactly one flag. It makes no memory request and no register write.
- R11: mem_req_valid and mem_addr stay steady until mem_req_ready. Completion happens in the cycle mem_rsp_valid is high: done, the destination write and any base write all come together for one cycle.
- R12: Any other halfword or 32-bit instruction gives done with not_byte_load, and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction halfword present |
| insn_hw | input | 16 | Instruction halfword |
| insn_ready | output | 1 | Unit accepts a halfword |
| rf_raddr | output | 4 | Base register read index |
| rf_rdata | input | 32 | Base register read value |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 8 | Returned byte |
| dst_we | output | 1 | Destination write enable |
| dst_waddr | output | 4 | Destination index |
| dst_wdata | output | 32 | Zero-extended byte |
| base_we | output | 1 | Base writeback enable |
| base_waddr | output | 4 | Base index |
| base_wdata | output | 32 | Updated address |
| done | output | 1 | Instruction finished |
| redir_literal | output | 1 | Belongs to the PC-relative variant |
| redir_preload | output | 1 | Belongs to the preload hint |
| redir_unpriv | output | 1 | Belongs to the unprivileged load |
| undef_insn | output | 1 | Undefined encoding |
| unpred_insn | output | 1 | Unpredictable encoding |
| not_byte_load | output | 1 | Not one of the three forms |

## Verification
The hardest situations to reach from the ports are the ones where several flag conditions overlap. Examples are a form-B encoding with destination 15 and a base of 15 at the same time, and destination 15 with writeback set, where the preload rule no longer applies and the case becomes unpredictable. Each of these needs exact bit patterns in both halfwords, so the stimulus builds them field by field. The bench also inserts idle gaps between the two halves and variable request stall and response latency. This checks that the address is held steady and that the base writeback lines up with the single completion cycle.

// File: rtl/byteld_pkg.sv
package byteld_pkg;

    localparam int RIDX_W = 4;
    localparam int IMM_W  = 12;
    localparam int NFLAG  = 6;

    // flag vector bit positions
    localparam int F_LIT    = 0;
    localparam int F_PLD    = 1;
    localparam int F_UNPRIV = 2;
    localparam int F_UNDEF  = 3;
    localparam int F_UNPRED = 4;
    localparam int F_NONE   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF2,
        ST_ISSUE,
        ST_WAIT,
        ST_FLAG
    } state_t;

    typedef struct packed {
        logic              is_load;
        logic [RIDX_W-1:0] base;
        logic [RIDX_W-1:0] dest;
        logic [IMM_W-1:0]  imm;
        logic              pre;
        logic              add;
        logic              wb;
        logic [NFLAG-1:0]  flags;
    } dec_t;

    function automatic logic is_first_half(input logic [15:0] h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

endpackage

// File: rtl/byteld_decoder.sv
module byteld_decoder
    import byteld_pkg::*;
(
    input  logic        is_long,
    input  logic [15:0] hw_a,
    input  logic [15:0] hw_b,
    output dec_t        dec
);

    always_comb begin
        dec = '0;
        if (!is_long) begin
            if (hw_a[15:11] == 5'b01111) begin
                dec.is_load = 1'b1;
                dec.imm     = {7'd0, hw_a[10:6]};
                dec.base    = {1'b0, hw_a[5:3]};
                dec.dest    = {1'b0, hw_a[2:0]};
                dec.pre     = 1'b1;
                dec.add     = 1'b1;
            end else begin
                dec.flags[F_NONE] = 1'b1;
            end
        end else begin
            dec.base = hw_a[3:0];
            dec.dest = hw_b[15:12];
            if (hw_a[15:4] == 12'hF89) begin
                dec.imm = hw_b[11:0];
                dec.pre = 1'b1;
                dec.add = 1'b1;
                if (dec.dest == 4'd15)      dec.flags[F_PLD]    = 1'b1;
                else if (dec.base == 4'd15) dec.flags[F_LIT]    = 1'b1;
                else if (dec.dest == 4'd13) dec.flags[F_UNPRED] = 1'b1;
                else                        dec.is_load         = 1'b1;
            end else if (hw_a[15:4] == 12'hF81 && hw_b[11]) begin
                dec.imm = {4'd0, hw_b[7:0]};
                dec.pre = hw_b[10];
                dec.add = hw_b[9];
                dec.wb  = hw_b[8];
                if (dec.dest == 4'd15 && dec.pre && !dec.add && !dec.wb)
                    dec.flags[F_PLD] = 1'b1;
                else if (dec.base == 4'd15)
                    dec.flags[F_LIT] = 1'b1;
                else if (dec.pre && dec.add && !dec.wb)
                    dec.flags[F_UNPRIV] = 1'b1;
                else if (!dec.pre && !dec.wb)
                    dec.flags[F_UNDEF] = 1'b1;
                else if (dec.dest == 4'd13 || dec.dest == 4'd15 ||
                         (dec.wb && dec.base == dec.dest))
                    dec.flags[F_UNPRED] = 1'b1;
                else
                    dec.is_load = 1'b1;
            end else begin
                dec.flags[F_NONE] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/byteld_agen.sv
module byteld_agen
    import byteld_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             add,
    input  logic             pre,
    output logic [XLEN-1:0]  off_addr,
    output logic [XLEN-1:0]  req_addr
);

    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        imm_ext  = {{PAD_W{1'b0}}, imm};
        off_addr = add ? (base_val + imm_ext) : (base_val - imm_ext);
        req_addr = pre ? off_addr : base_val;
    end

endmodule

// File: rtl/byteld_unit.sv
module byteld_unit
    import byteld_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [15:0]       insn_hw,
    output logic              insn_ready,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    output logic              dst_we,
    output logic [RIDX_W-1:0] dst_waddr,
    output logic [XLEN-1:0]   dst_wdata,
    output logic              base_we,
    output logic [RIDX_W-1:0] base_waddr,
    output logic [XLEN-1:0]   base_wdata,
    output logic              done,
    output logic              redir_literal,
    output logic              redir_preload,
    output logic              redir_unpriv,
    output logic              undef_insn,
    output logic              unpred_insn,
    output logic              not_byte_load
);

    localparam int ZPAD_W = XLEN - BYTE_W;

    state_t          state_q, state_d;
    logic [15:0]     hw1_q;
    dec_t            dec_w, dec_q;
    logic [XLEN-1:0] off_w, off_q;
    logic            take;
    logic [NFLAG-1:0] flag_out;

    assign take = insn_valid && insn_ready;

    byteld_decoder u_dec (
        .is_long (state_q == ST_HALF2),
        .hw_a    ((state_q == ST_HALF2) ? hw1_q : insn_hw),
        .hw_b    (insn_hw),
        .dec     (dec_w)
    );

    byteld_agen #(.XLEN(XLEN)) u_agen (
        .base_val (rf_rdata),
        .imm      (dec_q.imm),
        .add      (dec_q.add),
        .pre      (dec_q.pre),
        .off_addr (off_w),
        .req_addr (mem_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (insn_valid) begin
                          if (is_first_half(insn_hw)) state_d = ST_HALF2;
                          else if (dec_w.is_load)     state_d = ST_ISSUE;
                          else                        state_d = ST_FLAG;
                      end
            ST_HALF2: if (insn_valid) state_d = dec_w.is_load ? ST_ISSUE : ST_FLAG;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            ST_FLAG:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw1_q <= '0;
            dec_q <= '0;
            off_q <= '0;
        end else begin
            if (take && state_q == ST_IDLE) hw1_q <= insn_hw;
            if (take && !(state_q == ST_IDLE && is_first_half(insn_hw))) dec_q <= dec_w;
            if (state_q == ST_ISSUE && mem_req_ready) off_q <= off_w;
        end
    end

    // outputs
    always_comb begin
        insn_ready    = 1'b0;
        mem_req_valid = 1'b0;
        dst_we        = 1'b0;
        base_we       = 1'b0;
        done          = 1'b0;
        flag_out      = '0;
        unique case (state_q)
            ST_IDLE, ST_HALF2: insn_ready = 1'b1;
            ST_ISSUE:          mem_req_valid = 1'b1;
            ST_WAIT: begin
                dst_we  = mem_rsp_valid;
                base_we = mem_rsp_valid && dec_q.wb;
                done    = mem_rsp_valid;
            end
            ST_FLAG: begin
                done     = 1'b1;
                flag_out = dec_q.flags;
            end
            default: ;
        endcase
    end

    assign rf_raddr      = dec_q.base;
    assign dst_waddr     = dec_q.dest;
    assign dst_wdata     = {{ZPAD_W{1'b0}}, mem_rsp_data};
    assign base_waddr    = dec_q.base;
    assign base_wdata    = off_q;
    assign redir_literal = flag_out[F_LIT];
    assign redir_preload = flag_out[F_PLD];
    assign redir_unpriv  = flag_out[F_UNPRIV];
    assign undef_insn    = flag_out[F_UNDEF];
    assign unpred_insn   = flag_out[F_UNPRED];
    assign not_byte_load = flag_out[F_NONE];

    // R11: request held steady until accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: at most one flag, and flagged completion has no side effects
    p_flag_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_out));
    p_flag_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_out) |-> (done && !dst_we && !base_we && !mem_req_valid));

    // R1: written data is zero-extended
    p_zext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dst_wdata[XLEN-1:BYTE_W] == '0));

    // R4: base writeback only alongside the destination write
    p_wb_with_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> (dst_we && done));

    // R2: after a leading half, wait for the second with no activity
    p_wait_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q == ST_IDLE && is_first_half(insn_hw)) |=>
        (insn_ready && !mem_req_valid && !done));

endmodule

// File: tb/byteld_unit_tb_top.sv
module byteld_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_hw = '0;
    logic        insn_ready;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        dst_we, base_we, done;
    logic [3:0]  dst_waddr, base_waddr;
    logic [31:0] dst_wdata, base_wdata;
    logic        redir_literal, redir_preload, redir_unpriv;
    logic        undef_insn, unpred_insn, not_byte_load;

    logic [31:0] regs [16];
    int n_chk = 0, n_fail = 0, cyc = 0;

    // expectations
    string       exp_tag = "R0";
    logic [5:0]  exp_flags;
    bit          exp_req, exp_wb, done_seen;
    logic [31:0] exp_addr, exp_wbaddr;
    logic [3:0]  exp_dest, exp_base;

    // memory responder config/state
    int          stall_cfg = 0, lat_cfg = 0, scnt = 0, lcnt = 0;
    bit          pend = 0, hs = 0;
    logic [7:0]  rsp_byte = '0;

    always #2 clk = ~clk;   // 250 MHz

    assign rf_rdata = regs[rf_raddr];

    byteld_unit dut_i (.*);

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [5:0] flag_vec();
        return {not_byte_load, unpred_insn, undef_insn, redir_unpriv, redir_preload, redir_literal};
    endfunction

    // behavioural reference: flag bits {none,unpred,undef,unpriv,preload,literal}
    task automatic model(logic [15:0] h1, logic [15:0] h2, bit two);
        int b, d, off; bit pre, add, wb, ok;
        exp_flags = '0; ok = 0; pre = 1; add = 1; wb = 0; b = 0; d = 0; off = 0;
        if (!two) begin
            if (h1[15:11] == 5'b01111) begin
                ok = 1; off = int'(h1[10:6]); b = int'(h1[5:3]); d = int'(h1[2:0]);
            end else exp_flags[5] = 1;
        end else begin
            b = int'(h1[3:0]); d = int'(h2[15:12]);
            if (h1[15:4] == 12'hF89) begin
                off = int'(h2[11:0]);
                if (d == 15) exp_flags[1] = 1;
                else if (b == 15) exp_flags[0] = 1;
                else if (d == 13) exp_flags[4] = 1;
                else ok = 1;
            end else if (h1[15:4] == 12'hF81 && h2[11]) begin
                off = int'(h2[7:0]); pre = h2[10]; add = h2[9]; wb = h2[8];
                if (d == 15 && pre && !add && !wb) exp_flags[1] = 1;
                else if (b == 15) exp_flags[0] = 1;
                else if (pre && add && !wb) exp_flags[2] = 1;
                else if (!pre && !wb) exp_flags[3] = 1;
                else if (d == 13 || d == 15 || (wb && b == d)) exp_flags[4] = 1;
                else ok = 1;
            end else exp_flags[5] = 1;
        end
        exp_req = ok; exp_wb = ok && wb;
        exp_dest = 4'(d); exp_base = 4'(b);
        exp_wbaddr = add ? regs[b] + 32'(off) : regs[b] - 32'(off);
        exp_addr = pre ? exp_wbaddr : regs[b];
    endtask

    // memory responder: drives just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            mem_req_ready = 0; mem_rsp_valid = 0; pend = 0; hs = 0; scnt = 0;
        end else begin
            mem_rsp_valid = 0;
            if (hs) begin pend = 1; lcnt = lat_cfg; end
            if (pend) begin
                if (lcnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = rsp_byte; pend = 0; end
                else lcnt--;
            end
            if (mem_req_valid) begin mem_req_ready = (scnt >= stall_cfg); scnt++; end
            else begin mem_req_ready = 0; scnt = 0; end
            hs = mem_req_valid && mem_req_ready;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid)
                chk(exp_req && mem_addr == exp_addr, exp_req ? exp_tag : "R10", mem_addr, exp_addr);
            if (dst_we) begin
                chk(exp_req && dst_waddr == exp_dest, exp_req ? exp_tag : "R10", 32'(dst_waddr), 32'(exp_dest));
                chk(dst_wdata == {24'd0, rsp_byte}, "R1", dst_wdata, {24'd0, rsp_byte});
            end
            if (base_we != (dst_we && exp_wb))
                chk(0, "R4", 32'(base_we), 32'(dst_we && exp_wb));
            if (base_we)
                chk(base_waddr == exp_base && base_wdata == exp_wbaddr, "R4", base_wdata, exp_wbaddr);
            if (done) begin
                chk(!done_seen, "R11", 32'(done_seen), 0);
                chk(flag_vec() == exp_flags, exp_tag, 32'(flag_vec()), 32'(exp_flags));
                done_seen = 1;
            end else if (flag_vec() != 0)
                chk(0, "R10", 32'(flag_vec()), 0);
        end
    end

    task automatic run(string tag, logic [15:0] h1, logic [15:0] h2, bit two,
                       int gap, int stall, int lat, logic [7:0] b);
        exp_tag = tag; stall_cfg = stall; lat_cfg = lat; rsp_byte = b;
        model(h1, h2, two);
        done_seen = 0;
        @(posedge clk); #1;
        insn_valid = 1; insn_hw = h1;
        @(posedge clk); #1;
        if (two) begin
            insn_valid = 0;
            for (int i = 0; i < gap; i++) begin
                @(negedge clk);
                chk(insn_ready && !mem_req_valid && !done, "R2", 32'(mem_req_valid), 0);
                @(posedge clk); #1;
            end
            insn_valid = 1; insn_hw = h2;
            @(posedge clk); #1;
        end
        insn_valid = 0;
        for (int i = 0; i < 40 && !done_seen; i++) @(posedge clk);
        chk(done_seen, tag, 32'(done_seen), 1);
    endtask

    function automatic logic [15:0] sh(logic [4:0] i, logic [2:0] bb, logic [2:0] d);
        return {5'b01111, i, bb, d};
    endfunction
    function automatic logic [15:0] lb2(logic [3:0] d, bit p, bit u, bit w, logic [7:0] i);
        return {d, 1'b1, p, u, w, i};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog R11: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0100;
        regs[9] = 32'h0000_0005;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(insn_ready && !mem_req_valid && !done && !dst_we && !base_we, "R11", 32'(insn_ready), 1);

        // R1 short form, then with stall and latency (R11)
        run("R1",  sh(5'd7, 3'd2, 3'd5), 16'h0, 0, 0, 0, 0, 8'hA5);
        run("R11", sh(5'd31, 3'd3, 3'd1), 16'h0, 0, 0, 3, 4, 8'hFF);
        // R3 form A, with a gap between halves (R2)
        run("R3",  {12'hF89, 4'd4}, {4'd3, 12'hFFF}, 1, 3, 0, 1, 8'h3C);
        run("R2",  {12'hF89, 4'd6}, {4'd0, 12'h123}, 1, 5, 1, 0, 8'h80);
        // R4 form B index/add/writeback combinations
        run("R4",  {12'hF81, 4'd6}, lb2(4'd7, 1, 1, 1, 8'h10), 1, 0, 0, 0, 8'h11);
        run("R4",  {12'hF81, 4'd6}, lb2(4'd7, 1, 0, 1, 8'h10), 1, 0, 2, 0, 8'h22);
        run("R4",  {12'hF81, 4'd2}, lb2(4'd8, 0, 1, 1, 8'hFF), 1, 1, 0, 2, 8'h33);
        run("R4",  {12'hF81, 4'd2}, lb2(4'd8, 0, 0, 1, 8'h40), 1, 0, 0, 0, 8'h44);
        run("R4",  {12'hF81, 4'd5}, lb2(4'd14, 1, 0, 0, 8'h01), 1, 0, 0, 0, 8'h55);
        run("R4",  {12'hF81, 4'd9}, lb2(4'd0, 1, 0, 1, 8'h10), 1, 0, 0, 0, 8'h66);
        // R5 literal redirect
        run("R5",  {12'hF89, 4'd15}, {4'd2, 12'h004}, 1, 0, 0, 0, 8'h00);
        run("R5",  {12'hF81, 4'd15}, lb2(4'd2, 1, 1, 1, 8'h04), 1, 0, 0, 0, 8'h00);
        // R6 preload redirect, including priority over base 15
        run("R6",  {12'hF89, 4'd3}, {4'd15, 12'h010}, 1, 0, 0, 0, 8'h00);
        run("R6",  {12'hF81, 4'd15}, lb2(4'd15, 1, 0, 0, 8'h10), 1, 0, 0, 0, 8'h00);
        // R7 unprivileged, R8 undefined
        run("R7",  {12'hF81, 4'd3}, lb2(4'd4, 1, 1, 0, 8'h10), 1, 0, 0, 0, 8'h00);
        run("R8",  {12'hF81, 4'd3}, lb2(4'd4, 0, 1, 0, 8'h10), 1, 0, 0, 0, 8'h00);
        // R9 unpredictable
        run("R9",  {12'hF89, 4'd3}, {4'd13, 12'h010}, 1, 0, 0, 0, 8'h00);
        run("R9",  {12'hF81, 4'd3}, lb2(4'd15, 1, 1, 1, 8'h10), 1, 0, 0, 0, 8'h00);
        run("R9",  {12'hF81, 4'd3}, lb2(4'd13, 1, 0, 1, 8'h10), 1, 0, 0, 0, 8'h00);
        run("R9",  {12'hF81, 4'd7}, lb2(4'd7, 0, 1, 1, 8'h10), 1, 0, 0, 0, 8'h00);
        // R12 other encodings
        run("R12", 16'h0000, 16'h0, 0, 0, 0, 0, 8'h00);
        run("R12", {12'hF8A, 4'd1}, 16'h1234, 1, 0, 0, 0, 8'h00);
        run("R12", {12'hF81, 4'd1}, 16'h2000, 1, 0, 0, 0, 8'h00);
        // back-to-back load after flagged cases
        run("R1",  sh(5'd0, 3'd0, 3'd7), 16'h0, 0, 0, 0, 0, 8'h01);

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule